// File: doc/BRIEF.md
# Receive Event Interrupt Status Register

This block holds the eight receive-side interrupt flags of one channel of a serial frame controller. The receiver sends one-cycle event pulses: message end, frame start, peer status change, protocol error, lock loss, carrier change, FIFO overflow and FIFO pool full. Each pulse is latched into its own status bit. A mask register sits beside the status bits. A visibility input decides whether a masked event still sets its status bit.

Only unmasked status bits raise the level-sensitive interrupt line and the summary bit that feeds a global status register. A CPU read returns the current contents and clears every bit. A separate acknowledge from the vector logic clears only the message-end bit, the pool-full bit, or both. A chip with two channels uses one instance per channel, and each instance is decoded at its own address outside this block.

Top module: `rx_irq_status`

## Requirements
- R1: After synchronous reset the status register is 0x00, the mask register is 0xFF (all masked), and `irq_o` and `summary_o` are low.
- R2: Status bit positions, MSB to LSB: 7 message end, 6 frame start, 5 peer status change, 4 protocol error, 3 lock loss, 2 carrier change, 1 FIFO overflow, 0 FIFO pool full. A pulse on `evt_i[k]` can only set status bit k.
- R3: An event pulse on an unmasked bit sets that status bit on the next clock edge. The bit then stays set until a clear reaches it.
- R4: While `rd_en_i` is high, `rd_data_o` shows the contents from before the clear. On the following edge every status bit is cleared.
- R5: An event pulse that arrives in the same cycle as a clear (read or vector acknowledge) leaves its bit set after that edge.
- R6: When `vec_ack_i` is high, `vec_sel_i` chooses what to clear: 2'b01 clears bit 7, 2'b10 clears bit 0, 2'b11 clears both, and 2'b00 clears nothing. Other bits are never affected, and `vec_sel_i` does nothing while `vec_ack_i` is low.
- R7: When `vis_i` is 1, a masked event sets its status bit, but `irq_o` and `summary_o` stay low for that bit.
- R8: When `vis_i` is 0, a masked event does not set its status bit.
- R9: `irq_o` and `summary_o` are high exactly when at least one status bit is set whose mask bit is 0.
- R10: Writing the mask (`mask_we_i`) takes effect on the next edge and is readable on `mask_o`. Unmasking a bit that is already set raises `irq_o` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | One-cycle event pulses from the receiver, one per status bit |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_wdata_i | input | 8 | Mask write data; 1 masks the bit |
| vis_i | input | 1 | 1: masked events still set their status bits |
| rd_en_i | input | 1 | CPU read strobe; clears the register on the edge |
| vec_ack_i | input | 1 | Interrupt vector emitted |
| vec_sel_i | input | 2 | Which FIFO bits the vector acknowledges |
| rd_data_o | output | 8 | Current status contents |
| mask_o | output | 8 | Current mask contents |
| irq_o | output | 1 | Active-high level interrupt |
| summary_o | output | 1 | Summary bit for the global status register |

## Verification
On every cycle the assertions check these rules: a read clears the register unless an event arrives in the same cycle, a pulse that is allowed through always sets its bit, and with visibility off a masked pulse never sets its bit. They also check that a fully masked register never raises the interrupt, that the vector acknowledge clears the bits it selects, and that the mask holds its value unless it is written. Only the bench scenarios can show the fixed bit layout, the read data from before the clear, the exact effect of each of the four acknowledge codes, and the interrupt rising when an already-set bit is unmasked.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    localparam int unsigned NUM_SRC = 8;

    // Status bit positions (layout is fixed)
    localparam int unsigned B_MSG_END     = 7;
    localparam int unsigned B_FRM_START   = 6;
    localparam int unsigned B_PEER_CHG    = 5;
    localparam int unsigned B_PROTO_ERR   = 4;
    localparam int unsigned B_LOCK_LOST   = 3;
    localparam int unsigned B_CARRIER_CHG = 2;
    localparam int unsigned B_FIFO_OVF    = 1;
    localparam int unsigned B_POOL_FULL   = 0;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef enum logic [1:0] {
        VACK_NONE = 2'b00,
        VACK_MSG  = 2'b01,
        VACK_POOL = 2'b10,
        VACK_BOTH = 2'b11
    } vack_sel_e;

    typedef struct packed {
        src_vec_t status;
        src_vec_t mask;
    } irq_view_t;

    // Bits that a vector acknowledge is allowed to clear
    function automatic src_vec_t vack_clear_bits(input logic ack, input vack_sel_e sel);
        src_vec_t m;
        m = '0;
        if (ack) begin
            m[B_MSG_END]   = (sel == VACK_MSG)  || (sel == VACK_BOTH);
            m[B_POOL_FULL] = (sel == VACK_POOL) || (sel == VACK_BOTH);
        end
        return m;
    endfunction

    function automatic bit bit_clears_on_vack(input int unsigned idx);
        return (idx == B_MSG_END) || (idx == B_POOL_FULL);
    endfunction

endpackage

// File: rtl/rx_irq_mask_reg.sv
module rx_irq_mask_reg
    import rx_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  src_vec_t wdata_i,
    output src_vec_t mask_o
);
    src_vec_t mask_q;

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '1;
        else if (we_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    // R10
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(mask_q));

endmodule

// File: rtl/rx_irq_bit_cell.sv
module rx_irq_bit_cell #(
    parameter bit VACK_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic mask_i,
    input  logic vis_i,
    input  logic rd_clr_i,
    input  logic vack_clr_i,
    output logic q_o
);
    logic q;
    logic set_ok;
    logic clr;
    logic vack_path;

    assign set_ok = evt_i & (~mask_i | vis_i);

    generate
        if (VACK_CLR) begin : g_vack
            assign vack_path = vack_clr_i;
        end else begin : g_novack
            assign vack_path = vack_clr_i & 1'b0;
        end
    endgenerate

    assign clr = rd_clr_i | vack_path;

    always_ff @(posedge clk) begin
        if (rst)         q <= 1'b0;
        else if (set_ok) q <= 1'b1;
        else if (clr)    q <= 1'b0;
    end

    assign q_o = q;

    // R4
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr_i && !evt_i) |=> !q);

    // R3 R5
    evt_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i && (!mask_i || vis_i)) |=> q);

    // R8
    hidden_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_i && mask_i && !vis_i && !q && !$past(rst)) |=> !q);

endmodule

// File: rtl/rx_irq_reduce.sv
module rx_irq_reduce
    import rx_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  irq_view_t view_i,
    output logic      irq_o,
    output logic      summary_o
);
    src_vec_t pend;

    assign pend      = view_i.status & ~view_i.mask;
    assign irq_o     = |pend;
    assign summary_o = |pend;

    // R7 R9
    all_masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (&view_i.mask) |-> (!irq_o && !summary_o));

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (view_i.status == '0) |-> !irq_o);

endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status
    import rx_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] evt_i,
    input  logic       mask_we_i,
    input  logic [7:0] mask_wdata_i,
    input  logic       vis_i,
    input  logic       rd_en_i,
    input  logic       vec_ack_i,
    input  logic [1:0] vec_sel_i,
    output logic [7:0] rd_data_o,
    output logic [7:0] mask_o,
    output logic       irq_o,
    output logic       summary_o
);
    src_vec_t  mask;
    src_vec_t  status;
    src_vec_t  vack_clr;
    irq_view_t view;
    logic      rst_d;

    rx_irq_mask_reg u_mask (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mask_we_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask)
    );

    assign vack_clr = vack_clear_bits(vec_ack_i, vack_sel_e'(vec_sel_i));

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
            rx_irq_bit_cell #(.VACK_CLR(bit_clears_on_vack(i))) u_cell (
                .clk        (clk),
                .rst        (rst),
                .evt_i      (evt_i[i]),
                .mask_i     (mask[i]),
                .vis_i      (vis_i),
                .rd_clr_i   (rd_en_i),
                .vack_clr_i (vack_clr[i]),
                .q_o        (status[i])
            );
        end
    endgenerate

    assign view.status = status;
    assign view.mask   = mask;

    rx_irq_reduce u_reduce (
        .clk       (clk),
        .rst       (rst),
        .view_i    (view),
        .irq_o     (irq_o),
        .summary_o (summary_o)
    );

    assign rd_data_o = status;
    assign mask_o    = mask;

    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            reset_state_chk: assert (status == '0 && mask == '1 && !irq_o);
        end
    end

    // R6
    vack_msg_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack_i && vec_sel_i[0] && !evt_i[B_MSG_END]) |=> !status[B_MSG_END]);

    // R6
    vack_pool_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack_i && vec_sel_i[1] && !evt_i[B_POOL_FULL]) |=> !status[B_POOL_FULL]);

    // R6
    vack_spare_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_ack_i && !rd_en_i && status[B_FRM_START]) |=> status[B_FRM_START]);

endmodule

// File: tb/tb_rx_irq_status.sv
module tb_rx_irq_status;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] evt;
    logic       mask_we;
    logic [7:0] mask_wdata;
    logic       vis;
    logic       rd_en;
    logic       vec_ack;
    logic [1:0] vec_sel;
    logic [7:0] rd_data;
    logic [7:0] mask_rd;
    logic       irq;
    logic       summary;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_irq_status dut (
        .clk(clk), .rst(rst), .evt_i(evt), .mask_we_i(mask_we),
        .mask_wdata_i(mask_wdata), .vis_i(vis), .rd_en_i(rd_en),
        .vec_ack_i(vec_ack), .vec_sel_i(vec_sel), .rd_data_o(rd_data),
        .mask_o(mask_rd), .irq_o(irq), .summary_o(summary)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] e);
        evt = e; tick(); evt = '0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_wdata = m; mask_we = 1'b1; tick(); mask_we = 1'b0;
    endtask

    task automatic do_read();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        chk("R1 status", rd_data, 8'h00);
        chk("R1 mask", mask_rd, 8'hFF);
        chk("R1 irq", {irq, summary}, 2'b00);
        pulse(8'hFF);
        chk("R8 all masked vis0", rd_data, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] named [8];
        named = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01};
        set_mask(8'h00);
        chk("R10 mask readback", mask_rd, 8'h00);
        for (int k = 0; k < 8; k++) begin
            pulse(named[k]);
            chk("R2 R3 bit set", rd_data, named[k]);
            chk("R9 irq", {irq, summary}, 2'b11);
            tick();
            chk("R3 holds", rd_data, named[k]);
            rd_en = 1'b1;
            chk("R4 pre-clear data", rd_data, named[k]);
            tick(); rd_en = 1'b0;
            chk("R4 cleared", rd_data, 8'h00);
            chk("R9 irq low", irq, 0);
        end
    endtask

    task automatic t_read_race();
        pulse(8'h08);
        evt = 8'h40; rd_en = 1'b1;
        chk("R4 data", rd_data, 8'h08);
        tick(); evt = '0; rd_en = 1'b0;
        chk("R5 event kept over read", rd_data, 8'h40);
        do_read();
    endtask

    task automatic t_vack();
        pulse(8'hFF);
        vec_sel = 2'b11; tick();
        chk("R6 sel without ack", rd_data, 8'hFF);
        vec_ack = 1'b1; vec_sel = 2'b00; tick();
        chk("R6 none", rd_data, 8'hFF);
        vec_sel = 2'b01; tick();
        chk("R6 msg end", rd_data, 8'h7F);
        vec_sel = 2'b10; tick();
        chk("R6 pool full", rd_data, 8'h7E);
        vec_ack = 1'b0;
        pulse(8'h81);
        chk("R6 re-set", rd_data, 8'hFF);
        vec_ack = 1'b1; vec_sel = 2'b11; tick();
        chk("R6 both", rd_data, 8'h7E);
        evt = 8'h80; tick(); evt = '0;
        chk("R5 event kept over vack", rd_data, 8'hFE);
        vec_ack = 1'b0; vec_sel = 2'b00;
        do_read();
    endtask

    task automatic t_visibility();
        set_mask(8'hF0);
        vis = 1'b1;
        pulse(8'hF0);
        chk("R7 masked visible", rd_data, 8'hF0);
        chk("R7 no irq", {irq, summary}, 2'b00);
        set_mask(8'h70);
        chk("R10 unmask raises irq", {irq, summary}, 2'b11);
        do_read();
        vis = 1'b0;
        set_mask(8'h0F);
        pulse(8'hFF);
        chk("R8 masked hidden", rd_data, 8'hF0);
        do_read();
    endtask

    initial begin
        evt = '0; mask_we = 0; mask_wdata = '0; vis = 0;
        rd_en = 0; vec_ack = 0; vec_sel = '0; rst = 1;
        t_reset();
        t_layout();
        t_read_race();
        t_vack();
        t_visibility();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule